// File: doc/BRIEF.md
# Framed Serial Port with Divided Bit Clock

This block is the converter-side end of a synchronous serial link to a DSP host. It runs entirely on one fabric clock and produces the link's bit clock from it through two cascaded power-of-two dividers. Outgoing 16-bit words are preceded by a one-period sync pulse, then shifted out most significant bit first. Incoming words are recognised from a host-driven sync pulse and assembled into a parallel word.

A word to send is offered on `tx_word` with a single-cycle `tx_start` strobe. It waits in a holding register until the next bit-clock rising edge at which the transmitter is free, so a second word may be queued while one is still going out. A received word appears on `rx_word` together with a one-cycle `rx_valid` strobe. Output drivers are described by enable signals (`sdo_oe`, `sdofs_oe`) for a pad ring to use.

An asynchronous port-enable pin, resynchronised to the fabric clock, parks the link in a low-power state. While parked, the bit clock is held low, the outputs are released and the serial inputs are disregarded. On return the received word is still present, but every timing counter and any half-finished transfer start again from scratch.

Top module: `dsp_serial_port`

## Requirements
- R1: With M = 2^`mdiv_sel` and S = 2^`sdiv_sel`, `sclk` has a period of 2·M·S fabric clock cycles. Its first rising edge after the synchronised enable goes high comes M·S cycles after that, which is 2 + M·S cycles after `port_en` rises.
- R2: `sdo` and `sdofs` change only on the fabric clock edge at which `sclk` rises, and hold their value until the next such edge.
- R3: Each transmitted frame is one `sclk` period with `sdofs` = 1, followed directly by 16 periods carrying `tx_word` MSB first on `sdo`.
- R4: `sdo_oe` is 1 exactly during the 16 data periods of a frame. It is 0 during the sync period and while no word is being sent, and `sdofs` is never 1 while `sdo_oe` is 1.
- R5: A falling `sclk` edge that samples `sdifs` = 1 arms the receiver. The next 16 falling edges sample `sdi` MSB first. After the 16th, `rx_word` holds the word and `rx_valid` is 1 for exactly one fabric cycle.
- R6: While the synchronised enable is low, `sclk`, `sdo_oe`, `sdofs_oe` and `sdofs` are 0. Activity on `sdi` and `sdifs` produces no `rx_valid`, and a `tx_start` pulse sends nothing after the port is enabled again.
- R7: After the enable returns, `rx_word` keeps its earlier value, a frame cut off by the disable is not resumed, the divider restarts as stated in R1, and new frames work normally.
- R8: Synchronous active-low `rst_n` clears `rx_word`, `rx_valid`, `sclk`, `sdo_oe`, `sdofs` and any queued transmit word.
- R9: A `tx_start` during a frame queues the new word. Its sync period takes the `sclk` period directly after the last data bit of the current frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Asynchronous port enable, high to run |
| mdiv_sel | input | SEL_W | First divider stage setting, factor 2^value |
| sdiv_sel | input | SEL_W | Second divider stage setting, factor 2^value |
| tx_word | input | WORD_W | Word to transmit |
| tx_start | input | 1 | One-cycle strobe that loads `tx_word` for sending |
| sdi | input | 1 | Serial data from the host |
| sdifs | input | 1 | Receive frame sync from the host |
| sclk | output | 1 | Divided bit clock |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| sdofs | output | 1 | Transmit frame sync |
| sdofs_oe | output | 1 | Drive enable for `sdofs` |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |

## Verification
The bound checker watches on every cycle that data and sync move only with a rising bit clock, that the sync pulse never overlaps an enabled data output and is followed by data, that `rx_valid` is a single-cycle strobe, and that a disabled port releases its outputs and stops its clock. The exact bit-clock period for every divider combination, the MSB-first order of transmitted and received words, and the back-to-back queuing can only be shown by the bench's scenarios. The same holds for the restart latency after re-enabling, the retention of the received word across a disable, and the loss of a queued word on reset.

// File: rtl/sp_pkg.sv
// Package: shared types for the framed serial port.
// Assumes nothing beyond SystemVerilog 2017 enums.
package sp_pkg;

    // Transmit sequencer phase.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SYNC = 2'd1,
        TX_DATA = 2'd2
    } tx_phase_e;

endpackage

// File: rtl/sp_div_stage.sv
// Module: one power-of-two divider stage.
// Counts input ticks and emits one output tick per 2^sel input ticks.
// A setting of zero passes every input tick through. Assumes sel may
// change at any time; a count past the new limit wraps at once.
module sp_div_stage #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_out
);
    localparam int CNT_W = (1 << SEL_W) - 1;
    localparam logic [CNT_W-1:0] ONES = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count for the selected power of two.
    assign last     = ONES >> (SEL_W'(CNT_W) - sel);
    assign tick_out = tick_in && (cnt >= last);

    // Tick counter, cleared while the port is parked.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick_in) begin
            cnt <= tick_out ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sp_clkgen.sv
// Module: enable synchroniser and bit-clock generator.
// Resynchronises the asynchronous enable with two flops, chains two
// divider stages and toggles sclk on every half-period tick. Reports
// the fabric cycles in which sclk will rise or fall. Assumes one clock.
module sp_clkgen #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic [SEL_W-1:0] mdiv_sel,
    input  logic [SEL_W-1:0] sdiv_sel,
    output logic             en_sync,
    output logic             sclk,
    output logic             rise_ev,
    output logic             fall_ev
);
    localparam int NSTAGE = 2;

    logic                en_meta;
    logic [NSTAGE:0]     tick;
    logic [SEL_W-1:0]    sel_arr [NSTAGE];

    assign sel_arr[0] = mdiv_sel;
    assign sel_arr[1] = sdiv_sel;
    assign tick[0]    = en_sync;

    // Two-flop synchroniser for the asynchronous enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_meta <= 1'b0;
            en_sync <= 1'b0;
        end else begin
            en_meta <= port_en;
            en_sync <= en_meta;
        end
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        sp_div_stage #(.SEL_W(SEL_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (en_sync),
            .tick_in (tick[g]),
            .sel     (sel_arr[g]),
            .tick_out(tick[g+1])
        );
    end

    assign rise_ev = tick[NSTAGE] && !sclk;
    assign fall_ev = tick[NSTAGE] && sclk;

    // Bit clock: toggles per half-period tick, parked low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_sync) begin
            sclk <= 1'b0;
        end else if (tick[NSTAGE]) begin
            sclk <= ~sclk;
        end
    end
endmodule

// File: rtl/sp_tx.sv
// Module: transmit sequencer.
// Holds one queued word, and on sclk rising events emits a one-period
// sync pulse followed by WORD_W bits MSB first. Assumes rise_ev is a
// single-cycle event from the clock generator.
module sp_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_sync,
    input  logic              rise_ev,
    input  logic              tx_start,
    input  logic [WORD_W-1:0] tx_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sdofs
);
    import sp_pkg::*;

    localparam int CNT_W = $clog2(WORD_W + 1);

    tx_phase_e         phase;
    logic [WORD_W-1:0] hold;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              pend;

    // Sequencer: advances one step per rising sclk event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= TX_IDLE;
            hold   <= '0;
            shreg  <= '0;
            bitcnt <= '0;
            pend   <= 1'b0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
            sdofs  <= 1'b0;
        end else if (!en_sync) begin
            phase  <= TX_IDLE;
            bitcnt <= '0;
            pend   <= 1'b0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
            sdofs  <= 1'b0;
        end else begin
            if (rise_ev) begin
                if (phase == TX_SYNC) begin
                    phase  <= TX_DATA;
                    sdofs  <= 1'b0;
                    sdo_oe <= 1'b1;
                    sdo    <= shreg[WORD_W-1];
                    shreg  <= shreg << 1;
                    bitcnt <= CNT_W'(1);
                end else if (phase == TX_DATA && bitcnt != CNT_W'(WORD_W)) begin
                    sdo    <= shreg[WORD_W-1];
                    shreg  <= shreg << 1;
                    bitcnt <= bitcnt + 1'b1;
                end else begin
                    sdo_oe <= 1'b0;
                    sdo    <= 1'b0;
                    if (pend) begin
                        phase <= TX_SYNC;
                        sdofs <= 1'b1;
                        shreg <= hold;
                        pend  <= 1'b0;
                    end else begin
                        phase <= TX_IDLE;
                    end
                end
            end
            if (tx_start) begin
                hold <= tx_word;
                pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_rx.sv
// Module: receive sequencer.
// On sclk falling events, arms on a sampled sync pulse, then shifts
// WORD_W bits MSB first and publishes the word with a one-cycle strobe.
// The published word survives a disable; only reset clears it.
module sp_rx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_sync,
    input  logic              fall_ev,
    input  logic              sdi,
    input  logic              sdifs,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic              active;
    logic [CNT_W-1:0]  bitcnt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] next_sh;

    assign next_sh = {shreg[WORD_W-2:0], sdi};

    // Receiver: arm on sync, shift on falling events, publish at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            bitcnt   <= '0;
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!en_sync) begin
                active <= 1'b0;
                bitcnt <= '0;
            end else if (fall_ev) begin
                if (active) begin
                    shreg  <= next_sh;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == CNT_W'(WORD_W - 1)) begin
                        rx_word  <= next_sh;
                        rx_valid <= 1'b1;
                        bitcnt   <= '0;
                        active   <= sdifs;
                    end
                end else if (sdifs) begin
                    active <= 1'b1;
                    bitcnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/dsp_serial_port.sv
// Module: framed serial port top.
// Wires the enable synchroniser and bit-clock generator to the transmit
// and receive sequencers. Assumes a single fabric clock; sclk is a
// registered signal, not a clock used inside this block.
module dsp_serial_port #(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [SEL_W-1:0]  mdiv_sel,
    input  logic [SEL_W-1:0]  sdiv_sel,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_start,
    input  logic              sdi,
    input  logic              sdifs,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sdofs,
    output logic              sdofs_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    logic en_sync;
    logic rise_ev;
    logic fall_ev;

    sp_clkgen #(.SEL_W(SEL_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_en (port_en),
        .mdiv_sel(mdiv_sel),
        .sdiv_sel(sdiv_sel),
        .en_sync (en_sync),
        .sclk    (sclk),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    sp_tx #(.WORD_W(WORD_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_sync (en_sync),
        .rise_ev (rise_ev),
        .tx_start(tx_start),
        .tx_word (tx_word),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe),
        .sdofs   (sdofs)
    );

    sp_rx #(.WORD_W(WORD_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_sync (en_sync),
        .fall_ev (fall_ev),
        .sdi     (sdi),
        .sdifs   (sdifs),
        .rx_word (rx_word),
        .rx_valid(rx_valid)
    );

    // The sync output is driven whenever the port runs.
    assign sdofs_oe = en_sync;
endmodule

// File: rtl/sp_checker.sv
// Module: protocol checker for dsp_serial_port, attached by bind.
// Observes ports and the synchronised enable; drives nothing.
module sp_checker (
    input logic clk,
    input logic rst_n,
    input logic en_sync,
    input logic sclk,
    input logic sdo,
    input logic sdo_oe,
    input logic sdofs,
    input logic rx_valid
);
    // R2: driven data moves only with a rising bit clock.
    p_sdo_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !$stable(sdo)) |-> $rose(sclk));

    // R2: the sync pulse starts only with a rising bit clock.
    p_fs_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdofs) |-> $rose(sclk));

    // R3: the end of a sync pulse in a running port opens the data phase.
    p_fs_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_sync && $fell(sdofs)) |-> sdo_oe);

    // R4: sync and data output enable never overlap.
    p_fs_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sdofs |-> !sdo_oe);

    // R5: the receive strobe lasts one cycle.
    p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: a parked port stops its clock and releases its outputs.
    p_parked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_sync |=> (!sclk && !sdo_oe && !sdofs));
endmodule

bind dsp_serial_port sp_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_sync (en_sync),
    .sclk    (sclk),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe),
    .sdofs   (sdofs),
    .rx_valid(rx_valid)
);

// File: tb/dsp_serial_port_tb.sv
// Bench: sweeps all divider settings, sends and receives a word in each,
// then covers queuing, disable/re-enable and reset mid-frame.
module dsp_serial_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b1;
    logic [1:0]  mdiv_sel = '0;
    logic [1:0]  sdiv_sel = '0;
    logic [15:0] tx_word = '0;
    logic        tx_start = 1'b0;
    logic        sdi = 1'b0;
    logic        sdifs = 1'b0;
    logic        sclk, sdo, sdo_oe, sdofs, sdofs_oe, rx_valid;
    logic [15:0] rx_word;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dsp_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en),
        .mdiv_sel(mdiv_sel), .sdiv_sel(sdiv_sel),
        .tx_word(tx_word), .tx_start(tx_start),
        .sdi(sdi), .sdifs(sdifs),
        .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe),
        .sdofs(sdofs), .sdofs_oe(sdofs_oe),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_tx(input logic [15:0] w);
        @(negedge clk);
        tx_word  = w;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    // Waits for the next sclk rise; samples outputs at that negedge.
    task automatic watch_rise(output logic fs, output logic d, output logic oe, output int t);
        logic prev;
        bit   got;
        prev = sclk;
        got  = 0;
        fs = 0; d = 0; oe = 0; t = cyc;
        for (int i = 0; i < 400 && !got; i++) begin
            @(negedge clk);
            if (sclk && !prev) begin
                got = 1; fs = sdofs; d = sdo; oe = sdo_oe; t = cyc;
            end
            prev = sclk;
        end
        if (!got) chk("R1 sclk rise timeout", 0, 1);
    endtask

    // mode 0: search for sync; 1: next rise must be sync; 2: sync already seen.
    task automatic expect_frame(input logic [15:0] w, input int mode, input int ms);
        logic fs, d, oe;
        int   t0, t, bad, hold_bad;
        logic [15:0] got;
        bad = 0; hold_bad = 0; t0 = 0;
        if (mode != 2) begin
            watch_rise(fs, d, oe, t);
            if (mode == 1) begin
                chk("R9 queued sync follows last bit", fs, 1);
            end else begin
                for (int k = 0; k < 60 && !fs; k++) watch_rise(fs, d, oe, t);
                chk("R3 sync seen", fs, 1);
            end
            chk("R4 oe low in sync period", oe, 0);
            t0 = t;
        end
        for (int i = 0; i < 16; i++) begin
            watch_rise(fs, d, oe, t);
            if (i == 0 && mode == 0) chk("R1 sclk period", t - t0, 2 * ms);
            got[15-i] = d;
            if (!oe || fs) bad++;
            @(negedge clk);
            if (sdo !== d) hold_bad++;   // R2 data held past the rise
        end
        chk("R3 tx word MSB first", got, w);
        chk("R4 oe high in data bits", bad, 0);
        chk("R2 sdo stable after rise", hold_bad, 0);
    endtask

    task automatic send_rx(input logic [15:0] w);
        bit seen;
        @(posedge sclk); #1 sdifs = 1'b1;
        @(posedge sclk); #1 sdifs = 1'b0; sdi = w[15];
        for (int i = 14; i >= 0; i--) begin
            @(posedge sclk); #1 sdi = w[i];
        end
        seen = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (rx_valid) seen = 1;
        end
        sdi = 1'b0;
        chk("R5 rx_valid strobe", seen, 1);
        chk("R5 rx word MSB first", rx_word, w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic fs, d, oe;
        int t, n, vcnt, stray;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 sclk low in reset", sclk, 0);
        chk("R8 sdo_oe low in reset", sdo_oe, 0);
        chk("R8 sdofs low in reset", sdofs, 0);
        chk("R8 rx_valid low in reset", rx_valid, 0);
        chk("R8 rx_word cleared", rx_word, 0);
        rst_n = 1'b1;

        // R1/R3/R4/R5 sweep every divider combination
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                mdiv_sel = 2'(m);
                sdiv_sel = 2'(s);
                pulse_tx(16'hA5C3 ^ 16'(m << 4) ^ 16'(s << 9));
                expect_frame(16'hA5C3 ^ 16'(m << 4) ^ 16'(s << 9), 0, (1 << m) * (1 << s));
                watch_rise(fs, d, oe, t);
                chk("R4 oe low after frame", oe, 0);
                chk("R3 no sync without word", fs, 0);
                send_rx(16'h3C1E ^ 16'(m << 2) ^ 16'(s << 12));
            end
        end

        // R9 back-to-back frames, M=2 S=2
        @(negedge clk);
        mdiv_sel = 2'd1; sdiv_sel = 2'd1;
        pulse_tx(16'hF00D);
        fs = 0;
        for (int k = 0; k < 60 && !fs; k++) watch_rise(fs, d, oe, t);
        tx_word = 16'h1234; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        expect_frame(16'hF00D, 2, 4);
        expect_frame(16'h1234, 1, 4);
        watch_rise(fs, d, oe, t);
        chk("R9 idle after queue drained", oe, 0);

        // R6/R7 disable mid-frame, M=2 S=1
        @(negedge clk);
        mdiv_sel = 2'd1; sdiv_sel = 2'd0;
        send_rx(16'h5AA5);
        pulse_tx(16'hBEEF);
        fs = 0;
        for (int k = 0; k < 60 && !fs; k++) watch_rise(fs, d, oe, t);
        repeat (3) watch_rise(fs, d, oe, t);
        @(negedge clk);
        port_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 sclk parked", sclk, 0);
        chk("R6 sdo_oe released", sdo_oe, 0);
        chk("R6 sdofs_oe released", sdofs_oe, 0);
        chk("R6 sdofs low", sdofs, 0);
        vcnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            sdifs    = (i % 3 == 0);
            sdi      = i[0];
            tx_start = (i == 5);
            if (rx_valid) vcnt++;
        end
        sdifs = 1'b0; sdi = 1'b0; tx_start = 1'b0;
        chk("R6 inputs ignored while parked", vcnt, 0);
        port_en = 1'b1;
        n = 0;
        while (!sclk && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R7 restart latency", n, 2 + 2);
        chk("R7 rx_word retained", rx_word, 16'h5AA5);
        stray = 0;
        for (int k = 0; k < 20; k++) begin
            watch_rise(fs, d, oe, t);
            if (fs || oe || rx_valid) stray++;
        end
        chk("R7 cut frame not resumed, R6 tx_start ignored", stray, 0);
        pulse_tx(16'h0F0F);
        expect_frame(16'h0F0F, 0, 2);

        // R8 reset mid-frame drops the word and clears rx_word
        pulse_tx(16'hC001);
        fs = 0;
        for (int k = 0; k < 60 && !fs; k++) watch_rise(fs, d, oe, t);
        watch_rise(fs, d, oe, t);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 sdo_oe cleared", sdo_oe, 0);
        chk("R8 sclk cleared", sclk, 0);
        chk("R8 rx_word cleared mid-run", rx_word, 0);
        rst_n = 1'b1;
        stray = 0;
        for (int k = 0; k < 20; k++) begin
            watch_rise(fs, d, oe, t);
            if (fs || oe) stray++;
        end
        chk("R8 queued word dropped", stray, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule